// File: doc/BRIEF.md
# Dual Cascadable 8-Bit Timer

This block holds two 8-bit up-counters, channel 0 and channel 1, each driven by a single-cycle count enable. Every channel has a 3-bit source selector. The selector can stop the counter, or pick one of three taps of a shared free-running prescaler. It can also pick a cascade event from the other channel, or pick an external pin counted on its rising edge, its falling edge or both edges. The cascade is asymmetric. Channel 0 can count overflows of channel 1. Channel 1 can count compare-A events of channel 0. If both channels pick the cascade source together, neither channel counts.

Each channel also has two compare registers (A and B) and a status register. The status register holds three event flags: compare B, compare A and overflow. Hardware sets these flags. Software clears a flag by writing a zero to it. The status register also holds a 4-bit output-select field, which is stored but drives no pins. All registers sit on a plain synchronous register bus: a write strobe, an address, write data and combinational read data. The external pins are resynchronised inside the block. The counters, flags and prescaler all run on the system clock.

Top module: `tmr8_pair`

## Requirements
- R1: After reset, each channel reads as follows: source selector 0, count 0, both compare registers 0xFF. The channel 0 status reads 0x00 and the channel 1 status reads 0x10.
- R2: With source code 0, the counter never advances, whatever happens on either external pin.
- R3: Codes 1, 2 and 3 advance the counter once per falling transition of prescaler bits 2, 5 and 12. The prescaler is a 13-bit counter incremented every clock. So over any window of 8·k, 64·k or 8192·k clocks, the counter advances by exactly k.
- R4: Code 4 on channel 0 advances it once per channel 1 overflow. Code 4 on channel 1 advances it once per compare-A event of channel 0.
- R5: When both channels hold code 4, neither channel advances. This holds even when the events that would feed them occur.
- R6: Codes 5, 6 and 7 count the channel's external pin on its rising edges, its falling edges and both edges. The pin passes through a two-flop synchroniser first.
- R7: The overflow flag (status bit 5) sets when a count enable moves the counter from 255 to 0.
- R8: A compare flag sets in the cycle after the counter and the compare register become equal. Equality can start through counting or through a bus write to either register. Compare B is bit 7 and compare A is bit 6. A compare-A event of channel 0 is defined the same way.
- R9: Writing 0 to a flag bit clears it, and writing 1 leaves it unchanged. When a hardware set and a clearing write fall in the same cycle, the flag ends up set.
- R10: Status bits 3..0 are a read/write output-select field. Status bit 4 is read/write on channel 0. On channel 1, bit 4 always reads 1 and ignores writes.
- R11: A register is selected by address bit 3 (the channel) and bits 2..0 (0 source, 1 status, 2 compare A, 3 compare B, 4 count). The count register is writable. Indices 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, taken on the rising clock edge |
| bus_addr | input | 4 | Register address: channel in bit 3, register index in bits 2..0 |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| ext_in0 | input | 1 | External count pin of channel 0, asynchronous |
| ext_in1 | input | 1 | External count pin of channel 1, asynchronous |

## Verification
The assertions rely on a few assumptions about the inputs:
- rst_n is held low for at least one clock edge before any check matters.
- The external pins only need to be stable long enough for the two-flop synchroniser to take them, so a high or low phase must last at least one full clock.
- Bus writes are single-cycle strobes with a defined address.

The bench keeps within these limits. It drives every input on the falling clock edge and holds each pin level for three clocks. It waits out the synchroniser latency before reading any count. The prescaler rates are measured over windows that are whole multiples of the tap period, so the expected advance is exact whatever the phase.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

  // Count source codes held in each channel's selector
  typedef enum logic [2:0] {
    SRC_OFF       = 3'd0,
    SRC_DIV_LO    = 3'd1,
    SRC_DIV_MID   = 3'd2,
    SRC_DIV_HI    = 3'd3,
    SRC_CASCADE   = 3'd4,
    SRC_EXT_RISE  = 3'd5,
    SRC_EXT_FALL  = 3'd6,
    SRC_EXT_BOTH  = 3'd7
  } clk_src_e;

  // Register index inside one channel
  typedef enum logic [2:0] {
    RI_SRC   = 3'd0,
    RI_STAT  = 3'd1,
    RI_CMPA  = 3'd2,
    RI_CMPB  = 3'd3,
    RI_COUNT = 3'd4
  } reg_idx_e;

  localparam int unsigned N_TAPS   = 3;
  localparam int unsigned BIT_CMB  = 7;
  localparam int unsigned BIT_CMA  = 6;
  localparam int unsigned BIT_OVF  = 5;
  localparam int unsigned BIT_AUX  = 4;
  localparam int unsigned OSEL_W   = 4;

  // Turns a selector code and the candidate events into one count enable
  function automatic logic pick_tick(
    input clk_src_e            src,
    input logic [N_TAPS-1:0]   taps,
    input logic                casc,
    input logic                rise,
    input logic                fall
  );
    logic t;
    case (src)
      SRC_DIV_LO:   t = taps[0];
      SRC_DIV_MID:  t = taps[1];
      SRC_DIV_HI:   t = taps[2];
      SRC_CASCADE:  t = casc;
      SRC_EXT_RISE: t = rise;
      SRC_EXT_FALL: t = fall;
      SRC_EXT_BOTH: t = rise | fall;
      default:      t = 1'b0;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/tmr8_prescale.sv
module tmr8_prescale
  import tmr8_pkg::*;
#(
  parameter int unsigned PRE_W = 13,
  parameter int unsigned TAP_POS [N_TAPS] = '{2, 5, 12}
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [N_TAPS-1:0] tick
);

  logic [PRE_W-1:0]  pre_q;
  logic [N_TAPS-1:0] tap_prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + 1'b1;
  end

  for (genvar g = 0; g < N_TAPS; g++) begin : g_tap
    always_ff @(posedge clk) begin
      if (!rst_n) tap_prev_q[g] <= 1'b0;
      else        tap_prev_q[g] <= pre_q[TAP_POS[g]];
    end

    // one pulse per 1 -> 0 transition of the chosen prescaler bit
    assign tick[g] = tap_prev_q[g] & ~pre_q[TAP_POS[g]];

    p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tick[g] |=> !tick[g]);
  end

endmodule

// File: rtl/tmr8_edge_det.sv
module tmr8_edge_det #(
  parameter int unsigned SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);

  logic [SYNC_N-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_N-2:0], pin};
      last_q <= sync_q[SYNC_N-1];
    end
  end

  assign rise = sync_q[SYNC_N-1] & ~last_q;
  assign fall = ~sync_q[SYNC_N-1] & last_q;

  p_rise_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
  p_fall_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);

endmodule

// File: rtl/tmr8_chan.sv
module tmr8_chan
  import tmr8_pkg::*;
#(
  parameter int unsigned CNT_W    = 8,
  parameter bit          HAS_AUX  = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             wr_en,
  input  logic [2:0]       idx,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] rd_data,
  output clk_src_e         src,
  output logic             wrap_evt,
  output logic             cma_evt
);

  localparam logic [CNT_W-1:0] CNT_TOP  = '1;
  localparam logic [CNT_W-1:0] CMP_INIT = '1;

  clk_src_e            src_q;
  logic [CNT_W-1:0]    cnt_q, cmpa_q, cmpb_q;
  logic                fcmb_q, fcma_q, fovf_q, aux_q;
  logic [OSEL_W-1:0]   osel_q;
  logic                eqa_q, eqb_q;
  logic                eqa, eqb, cmb_evt;
  logic                cnt_wr, stat_wr;
  logic [7:0]          stat_rd;

  assign cnt_wr  = wr_en && (idx == RI_COUNT);
  assign stat_wr = wr_en && (idx == RI_STAT);

  // counter: a bus write wins over a count enable
  assign wrap_evt = tick_en && !cnt_wr && (cnt_q == CNT_TOP);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (cnt_wr)  cnt_q <= wr_data;
    else if (tick_en) cnt_q <= cnt_q + 1'b1;
  end

  // configuration and compare registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q  <= SRC_OFF;
      cmpa_q <= CMP_INIT;
      cmpb_q <= CMP_INIT;
      osel_q <= '0;
    end else if (wr_en) begin
      case (idx)
        RI_SRC:  src_q  <= clk_src_e'(wr_data[2:0]);
        RI_CMPA: cmpa_q <= wr_data;
        RI_CMPB: cmpb_q <= wr_data;
        RI_STAT: osel_q <= wr_data[OSEL_W-1:0];
        default: ;
      endcase
    end
  end

  // compare events fire when equality begins
  assign eqa     = (cnt_q == cmpa_q);
  assign eqb     = (cnt_q == cmpb_q);
  assign cma_evt = eqa & ~eqa_q;
  assign cmb_evt = eqb & ~eqb_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eqa_q <= 1'b0;
      eqb_q <= 1'b0;
    end else begin
      eqa_q <= eqa;
      eqb_q <= eqb;
    end
  end

  // flags: hardware set dominates a software zero-write
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fcmb_q <= 1'b0;
      fcma_q <= 1'b0;
      fovf_q <= 1'b0;
    end else begin
      fcmb_q <= cmb_evt  | (fcmb_q & ~(stat_wr & ~wr_data[BIT_CMB]));
      fcma_q <= cma_evt  | (fcma_q & ~(stat_wr & ~wr_data[BIT_CMA]));
      fovf_q <= wrap_evt | (fovf_q & ~(stat_wr & ~wr_data[BIT_OVF]));
    end
  end

  if (HAS_AUX) begin : g_aux_rw
    always_ff @(posedge clk) begin
      if (!rst_n)       aux_q <= 1'b0;
      else if (stat_wr) aux_q <= wr_data[BIT_AUX];
    end
  end else begin : g_aux_fixed
    assign aux_q = 1'b1;
  end

  assign stat_rd = {fcmb_q, fcma_q, fovf_q, aux_q, osel_q};

  always_comb begin
    case (idx)
      RI_SRC:   rd_data = CNT_W'(src_q);
      RI_STAT:  rd_data = CNT_W'(stat_rd);
      RI_CMPA:  rd_data = cmpa_q;
      RI_CMPB:  rd_data = cmpb_q;
      RI_COUNT: rd_data = cnt_q;
      default:  rd_data = '0;
    endcase
  end

  assign src = src_q;

  p_off_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (src_q == SRC_OFF && !cnt_wr) |=> $stable(cnt_q));
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !cnt_wr) |=> $stable(cnt_q));
  p_ovf_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (fovf_q && cnt_q == '0));
  p_cmpa_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cma_evt |=> fcma_q);
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !wr_data[BIT_OVF] && !wrap_evt) |=> !fovf_q);
  p_one_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fovf_q && !(stat_wr && !wr_data[BIT_OVF])) |=> fovf_q);

endmodule

// File: rtl/tmr8_pair.sv
module tmr8_pair
  import tmr8_pkg::*;
#(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned PRE_W  = 13,
  parameter int unsigned SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [3:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  input  logic             ext_in0,
  input  logic             ext_in1
);

  logic [N_TAPS-1:0] taps;
  logic              rise0, fall0, rise1, fall1;
  logic              en0, en1, wr0, wr1;
  logic              wrap0, wrap1, cma0, cma1;
  logic              casc_ok;
  clk_src_e          src0, src1;
  logic [CNT_W-1:0]  rd0, rd1;

  tmr8_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(taps)
  );

  tmr8_edge_det #(.SYNC_N(SYNC_N)) u_edge0 (
    .clk(clk), .rst_n(rst_n), .pin(ext_in0), .rise(rise0), .fall(fall0)
  );
  tmr8_edge_det #(.SYNC_N(SYNC_N)) u_edge1 (
    .clk(clk), .rst_n(rst_n), .pin(ext_in1), .rise(rise1), .fall(fall1)
  );

  // mutual cascade would need each channel to feed the other: block both
  assign casc_ok = !(src0 == SRC_CASCADE && src1 == SRC_CASCADE);
  assign en0 = pick_tick(src0, taps, wrap1 & casc_ok, rise0, fall0);
  assign en1 = pick_tick(src1, taps, cma0 & casc_ok, rise1, fall1);

  assign wr0 = bus_wr && !bus_addr[3];
  assign wr1 = bus_wr &&  bus_addr[3];

  tmr8_chan #(.CNT_W(CNT_W), .HAS_AUX(1'b1)) u_ch0 (
    .clk(clk), .rst_n(rst_n), .tick_en(en0), .wr_en(wr0),
    .idx(bus_addr[2:0]), .wr_data(bus_wdata), .rd_data(rd0),
    .src(src0), .wrap_evt(wrap0), .cma_evt(cma0)
  );
  tmr8_chan #(.CNT_W(CNT_W), .HAS_AUX(1'b0)) u_ch1 (
    .clk(clk), .rst_n(rst_n), .tick_en(en1), .wr_en(wr1),
    .idx(bus_addr[2:0]), .wr_data(bus_wdata), .rd_data(rd1),
    .src(src1), .wrap_evt(wrap1), .cma_evt(cma1)
  );

  assign bus_rdata = bus_addr[3] ? rd1 : rd0;

  p_mutual_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (src0 == SRC_CASCADE && src1 == SRC_CASCADE) |-> (!en0 && !en1));
  p_casc_fwd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (src1 == SRC_CASCADE && src0 != SRC_CASCADE && cma0) |-> en1);
  p_casc_back_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (src0 == SRC_CASCADE && src1 != SRC_CASCADE && wrap1) |-> en0);
  p_no_cross_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (src0 == SRC_OFF) |-> !en0);

endmodule

// File: tb/tmr8_pair_test.sv
module tmr8_pair_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       ext_in0 = 1'b0;
  logic       ext_in1 = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  localparam logic [3:0] A_SRC0 = 4'h0, A_STAT0 = 4'h1, A_CMPA0 = 4'h2,
                         A_CMPB0 = 4'h3, A_CNT0 = 4'h4;
  localparam logic [3:0] A_SRC1 = 4'h8, A_STAT1 = 4'h9, A_CMPA1 = 4'hA,
                         A_CMPB1 = 4'hB, A_CNT1 = 4'hC;

  always #2 clk = ~clk;  // 250 MHz

  tmr8_pair uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_in0(ext_in0), .ext_in1(ext_in1)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  // n full pulses (3 clocks high, 3 low), then wait out synchroniser latency
  task automatic pulses(input int ch, input int n);
    for (int i = 0; i < n; i++) begin
      if (ch == 0) ext_in0 = 1'b1; else ext_in1 = 1'b1;
      repeat (3) @(negedge clk);
      if (ch == 0) ext_in0 = 1'b0; else ext_in1 = 1'b0;
      repeat (3) @(negedge clk);
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic rate(input logic [2:0] code, input int win, input logic [7:0] exp);
    logic [7:0] c1, c2;
    wr(A_SRC0, {5'd0, code});
    repeat (3) @(negedge clk);
    rd(A_CNT0, c1);
    repeat (win - 1) @(negedge clk);
    rd(A_CNT0, c2);
    check($sformatf("R3 tap code %0d window %0d", code, win), c2 - c1, exp);
    wr(A_SRC0, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state, R11 unused indices
    rd(A_SRC0, v);  check("R1 src0", v, 8'h00);
    rd(A_SRC1, v);  check("R1 src1", v, 8'h00);
    rd(A_STAT0, v); check("R1 stat0", v, 8'h00);
    rd(A_STAT1, v); check("R1 stat1", v, 8'h10);
    rd(A_CMPA0, v); check("R1 cmpa0", v, 8'hFF);
    rd(A_CMPB1, v); check("R1 cmpb1", v, 8'hFF);
    rd(A_CNT0, v);  check("R1 cnt0", v, 8'h00);
    rd(A_CNT1, v);  check("R1 cnt1", v, 8'h00);
    for (int i = 5; i < 8; i++) begin
      rd(4'(i), v);      check("R11 unused ch0", v, 8'h00);
      rd(4'(i + 8), v);  check("R11 unused ch1", v, 8'h00);
    end

    // R2 disabled channel ignores its pin
    pulses(0, 5);
    rd(A_CNT0, v); check("R2 off ignores pin", v, 8'h00);

    // R3 prescaler taps
    rate(3'd1, 800, 8'd100);
    rate(3'd2, 6400, 8'd100);
    rate(3'd3, 16384, 8'd2);

    // R6 external modes on channel 1
    for (int m = 5; m < 8; m++) begin
      wr(A_SRC1, 8'(m));
      wr(A_CNT1, 8'h00);
      pulses(1, 10);
      rd(A_CNT1, v);
      check($sformatf("R6 ext mode %0d", m), v, (m == 7) ? 8'd20 : 8'd10);
    end
    rd(A_CNT0, v); wr(A_CNT0, v);  // channel 0 off: pin 1 had no effect
    wr(A_SRC1, 8'h00);

    // R4 channel 0 counts channel 1 overflows; R7 overflow flag
    wr(A_STAT1, 8'h00);
    wr(A_CNT1, 8'd250);
    wr(A_CNT0, 8'h00);
    wr(A_SRC1, 8'd7);
    wr(A_SRC0, 8'd4);
    pulses(1, 150);
    rd(A_CNT1, v); check("R4 ch1 after 300 edges", v, 8'd38);
    rd(A_CNT0, v); check("R4 ch0 counts ch1 wraps", v, 8'd2);
    rd(A_STAT1, v); check("R7 ovf flag ch1", v & 8'h20, 8'h20);
    wr(A_SRC0, 8'h00); wr(A_SRC1, 8'h00);

    // R4 channel 1 counts channel 0 compare-A events
    wr(A_CMPA0, 8'd3);
    wr(A_CNT0, 8'h00);
    wr(A_CNT1, 8'h00);
    wr(A_SRC0, 8'd5);
    wr(A_SRC1, 8'd4);
    pulses(0, 300);
    rd(A_CNT0, v); check("R6 ch0 rising count", v, 8'd44);
    rd(A_CNT1, v); check("R4 ch1 counts cmpA0", v, 8'd2);
    rd(A_STAT0, v); check("R7 ovf flag ch0", v & 8'h20, 8'h20);
    wr(A_SRC0, 8'h00);

    // R5 mutual cascade: a compare event made by a bus write must not count
    wr(A_CNT0, 8'd6);
    wr(A_SRC0, 8'd4);
    wr(A_CNT1, 8'h00);
    wr(A_CNT0, 8'd3);
    repeat (3) @(negedge clk);
    rd(A_CNT1, v); check("R5 mutual cascade blocked", v, 8'h00);
    wr(A_SRC0, 8'h00);
    wr(A_CNT0, 8'd6);
    wr(A_CNT0, 8'd3);
    repeat (3) @(negedge clk);
    rd(A_CNT1, v); check("R4 single cascade counts", v, 8'd1);
    wr(A_SRC1, 8'h00);

    // R8 compare-B sweep over every value
    wr(A_CMPA0, 8'hFF);
    for (int k = 0; k < 256; k++) begin
      wr(A_CNT0, 8'(k + 1));
      wr(A_STAT0, 8'h00);
      wr(A_CMPB0, 8'(k));
      rd(A_STAT0, v); check($sformatf("R8 cmpB %0d idle", k), v & 8'h80, 8'h00);
      wr(A_CNT0, 8'(k));
      rd(A_STAT0, v); check($sformatf("R8 cmpB %0d match", k), v & 8'h80, 8'h80);
    end

    // R9 write-one keeps, write-zero clears
    wr(A_STAT0, 8'hE0);
    rd(A_STAT0, v); check("R9 write one keeps", v & 8'h80, 8'h80);
    wr(A_STAT0, 8'h00);
    rd(A_STAT0, v); check("R9 write zero clears", v, 8'h00);

    // R9 set wins over same-cycle clear
    wr(A_CNT0, 8'd9);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = A_CMPA0; bus_wdata = 8'd9;
    @(negedge clk);
    bus_addr = A_STAT0; bus_wdata = 8'h00;
    @(negedge clk);
    bus_wr = 1'b0;
    rd(A_STAT0, v); check("R9 set wins", v, 8'h40);
    wr(A_STAT0, 8'h00);
    rd(A_STAT0, v); check("R9 clear after", v, 8'h00);

    // R10 auxiliary bits
    wr(A_STAT0, 8'h1F);
    rd(A_STAT0, v); check("R10 ch0 aux and osel", v, 8'h1F);
    wr(A_STAT0, 8'h05);
    rd(A_STAT0, v); check("R10 ch0 aux clear", v, 8'h05);
    wr(A_STAT1, 8'h0A);
    rd(A_STAT1, v); check("R10 ch1 aux fixed", v, 8'h1A);
    wr(A_STAT1, 8'h00);
    rd(A_STAT1, v); check("R10 ch1 zero write", v, 8'h10);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule